// File: doc/BRIEF.md
# Flash High-Voltage Control Register

This block is the control register that sits between the processor bus and an on-chip flash array's high-voltage circuitry. Software uses it to pick program, erase or margin-read mode, and then to switch high voltage on. Hardware interlocks filter every write, so an illegal combination never reaches the array. Program and erase cannot be active together. High voltage comes on only from a properly armed program or erase mode. Margin read and high voltage never coexist. A slow bus clock forces high voltage off.

The block also makes the charge-pump clock. A 2-bit select field divides the bus clock. The pump clock runs only while high voltage is enabled. All pins are plain control and status signals. The register port uses an address-hit qualifier, a write strobe and write data, with read data always presented combinationally. There is no streaming interface, so no valid/ready back-pressure applies.

Top module: `flash_hv_ctrl`

## Requirements
- R1: After reset, every control bit is 0, read data is 0, and both `pump_en` and `pump_clk` are 0.
- R2: Read data places program-select at bit 0, erase-select at bit 1, margin-read at bit 2 and high-voltage enable at bit 3. Bits 7:4 always read 0.
- R3: Program-select and erase-select are never both 1. A write that requests both keeps their previous values. A write that requests one of them while the other is held leaves the requested bit at 0, and the held bit takes the written value.
- R4: High-voltage enable goes from 0 to 1 only when all of these hold: program-select or erase-select is already 1 before the write, `latch_wr` was pulsed in a cycle after that mode bit became 1, and `bus_clk_ok` is 1. Otherwise the request is ignored.
- R5: Margin-read is 0 whenever high-voltage enable is 1. If a write turns high voltage on, margin-read is cleared in that same write. While high voltage is on, a write cannot set margin-read.
- R6: A write that leaves both program-select and erase-select at 0 also clears high-voltage enable in the same cycle.
- R7: While `bus_clk_ok` is 0, high-voltage enable is cleared on the next clock edge and cannot be set.
- R8: `pump_en` equals high-voltage enable, and `pump_clk` is 0 whenever `pump_en` is 0.
- R9: While high voltage is on, `pump_clk` toggles once every 2^`div_sel` bus-clock cycles, so `div_sel` 0..3 divides the bus clock by 2, 4, 8 and 16 in period.
- R10: A write strobe without `reg_sel` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Address hit on the control register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| div_sel | input | 2 | Pump clock divider select |
| bus_clk_ok | input | 1 | Bus clock is at or above the minimum for high-voltage work |
| latch_wr | input | 1 | Strobe for a write into the flash address range (arming step) |
| pump_clk | output | 1 | Gated charge-pump clock |
| pump_en | output | 1 | Charge pump on and high voltage routed to the array |
| mode_prog | output | 1 | Program mode selected |
| mode_erase | output | 1 | Erase mode selected |
| mode_margin | output | 1 | Margin-read mode selected |

## Verification
The assertions check the standing interlocks on every cycle. Program and erase are never both set. High voltage always has a mode behind it and never coexists with margin read. Each rise of high voltage is preceded by arming and an adequate bus clock. The pump clock is silent while the pump is off. Only the bench's scenarios can show that a rejected write leaves the right bits untouched, that the write-filter rules for simultaneous requests hold, and that each divider setting produces the stated toggle count.

// File: rtl/fhv_pkg.sv
package fhv_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned DIV_SEL_W = 2;
  localparam int unsigned CNT_W     = (1 << DIV_SEL_W) - 1;

  localparam int unsigned BIT_PROG   = 0;
  localparam int unsigned BIT_ERASE  = 1;
  localparam int unsigned BIT_MARGIN = 2;
  localparam int unsigned BIT_HV     = 3;
  localparam int unsigned CTRL_W     = 4;

  typedef struct packed {
    logic hv;
    logic margin;
    logic erase;
    logic prog;
  } ctrl_bits_t;
endpackage

// File: rtl/fhv_arm_track.sv
module fhv_arm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_act,
  input  logic latch_wr,
  output logic armed
);
  logic armed_q;

  // The arming strobe only counts once a mode bit is already registered.
  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= mode_act & (armed_q | latch_wr);
  end

  assign armed = armed_q;

  p_armed_needs_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> $past(mode_act));
endmodule

// File: rtl/fhv_ctrl_reg.sv
module fhv_ctrl_reg
  import fhv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              armed,
  input  logic              bus_clk_ok,
  output ctrl_bits_t        bits
);
  ctrl_bits_t q, d;
  logic req_p, req_e, req_m, req_hv;
  logic hv_grant;

  assign req_p  = wdata[BIT_PROG];
  assign req_e  = wdata[BIT_ERASE];
  assign req_m  = wdata[BIT_MARGIN];
  assign req_hv = wdata[BIT_HV];

  // High voltage may only turn on from an armed, already selected mode.
  assign hv_grant = (q.prog | q.erase) & armed & bus_clk_ok;

  always_comb begin
    d = q;
    if (wr_hit) begin
      if (req_p && req_e) begin
        d.prog  = q.prog;
        d.erase = q.erase;
      end else begin
        d.prog  = req_p & ~q.erase;
        d.erase = req_e & ~q.prog;
      end
      if (!req_hv)   d.hv = 1'b0;
      else if (q.hv) d.hv = 1'b1;
      else           d.hv = hv_grant;
      d.margin = req_m;
    end
    d.hv     = d.hv & (d.prog | d.erase) & bus_clk_ok;
    d.margin = d.margin & ~d.hv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign bits = q;

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(q.prog && q.erase));
  p_hv_rise_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.hv) |-> ($past(armed) && $past(bus_clk_ok)));
  p_margin_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q.hv |-> !q.margin);
  p_hv_needs_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q.hv |-> (q.prog || q.erase));
  p_slow_clk_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q.hv && !bus_clk_ok) |=> !q.hv);
endmodule

// File: rtl/fhv_pump_div.sv
module fhv_pump_div
  import fhv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 pump_clk
);
  logic [CNT_W-1:0] cnt_q, lim;
  logic             tog_q;

  // Limit is 2^div_sel - 1: every bit below div_sel is set.
  always_comb begin
    for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(div_sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pump_clk = tog_q & run;

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim) || $changed(div_sel));
endmodule

// File: rtl/flash_hv_ctrl.sv
module flash_hv_ctrl
  import fhv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 bus_clk_ok,
  input  logic                 latch_wr,
  output logic                 pump_clk,
  output logic                 pump_en,
  output logic                 mode_prog,
  output logic                 mode_erase,
  output logic                 mode_margin
);
  ctrl_bits_t bits;
  logic       armed;
  logic       unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_W];

  fhv_arm_track u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_act (bits.prog | bits.erase),
    .latch_wr (latch_wr),
    .armed    (armed)
  );

  fhv_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (reg_sel & reg_wr),
    .wdata      (reg_wdata[CTRL_W-1:0]),
    .armed      (armed),
    .bus_clk_ok (bus_clk_ok),
    .bits       (bits)
  );

  fhv_pump_div u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (bits.hv),
    .div_sel  (div_sel),
    .pump_clk (pump_clk)
  );

  assign reg_rdata   = {{(DATA_W-CTRL_W){1'b0}}, bits};
  assign pump_en     = bits.hv;
  assign mode_prog   = bits.prog;
  assign mode_erase  = bits.erase;
  assign mode_margin = bits.margin;

  p_pump_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_en |-> !pump_clk);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:CTRL_W] == '0);
endmodule

// File: tb/flash_hv_ctrl_tb.sv
module flash_hv_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0, latch_wr = 1'b0;
  logic       bus_clk_ok = 1'b1;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] div_sel = '0;
  logic       pump_clk, pump_en, mode_prog, mode_erase, mode_margin;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_hv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_sel(div_sel),
    .bus_clk_ok(bus_clk_ok), .latch_wr(latch_wr), .pump_clk(pump_clk),
    .pump_en(pump_en), .mode_prog(mode_prog), .mode_erase(mode_erase),
    .mode_margin(mode_margin)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic latch();
    @(negedge clk); latch_wr = 1'b1;
    @(negedge clk); latch_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_clk_ok = 1'b1;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 pump_en", pump_en, 0);
    chk("R1 pump_clk", pump_clk, 0);
  endtask

  task automatic t_layout();
    do_reset();
    wr(8'hF5);
    chk("R2 upper bits zero, prog+margin", reg_rdata, 8'h05);
    chk("R2 mode_prog pin", mode_prog, 1);
    chk("R2 mode_margin pin", mode_margin, 1);
    wr(8'h02); wr(8'h02);
    chk("R2 erase at bit1", reg_rdata, 8'h02);
    chk("R2 mode_erase pin", mode_erase, 1);
  endtask

  task automatic t_excl();
    do_reset();
    wr(8'h03);
    chk("R3 both from idle", reg_rdata, 8'h00);
    wr(8'h01);
    wr(8'h03);
    chk("R3 both keeps prior", reg_rdata, 8'h01);
    wr(8'h02);
    chk("R3 erase while prog held", reg_rdata, 8'h00);
  endtask

  task automatic t_arm();
    do_reset();
    wr(8'h08);
    chk("R4 hv without mode", reg_rdata, 8'h00);
    wr(8'h01); wr(8'h09);
    chk("R4 hv without latch", reg_rdata, 8'h01);
    do_reset();
    latch(); wr(8'h01); wr(8'h09);
    chk("R4 latch before mode", reg_rdata, 8'h01);
    latch(); wr(8'h09);
    chk("R4 armed hv set", reg_rdata, 8'h09);
    chk("R8 pump_en follows hv", pump_en, 1);
  endtask

  task automatic t_margin();
    do_reset();
    wr(8'h06); latch(); wr(8'h0E);
    chk("R5 margin cleared on hv rise", reg_rdata, 8'h0A);
    wr(8'h0E);
    chk("R5 margin blocked while hv", reg_rdata, 8'h0A);
  endtask

  task automatic t_clear_mode();
    do_reset();
    wr(8'h01); latch(); wr(8'h09);
    wr(8'h08);
    chk("R6 clearing prog drops hv", reg_rdata, 8'h00);
    chk("R8 pump_en off", pump_en, 0);
    chk("R8 pump_clk off", pump_clk, 0);
  endtask

  task automatic t_busclk();
    do_reset();
    wr(8'h01); latch();
    bus_clk_ok = 1'b0;
    wr(8'h09);
    chk("R7 slow clock blocks hv", reg_rdata, 8'h01);
    bus_clk_ok = 1'b1;
    wr(8'h09);
    chk("R7 hv after clock ok", reg_rdata, 8'h09);
    @(negedge clk); bus_clk_ok = 1'b0;
    @(negedge clk);
    chk("R7 slow clock drops hv", reg_rdata, 8'h01);
    bus_clk_ok = 1'b1;
  endtask

  task automatic t_nosel();
    do_reset();
    wr(8'h01, 1'b0);
    chk("R10 write without select", reg_rdata, 8'h00);
    wr(8'h01); latch(); wr(8'h00, 1'b0);
    chk("R10 clear without select", reg_rdata, 8'h01);
  endtask

  task automatic t_pump();
    for (int d = 0; d < 4; d++) begin
      int tgl = 0;
      logic prev;
      do_reset();
      div_sel = 2'(d);
      wr(8'h01); latch(); wr(8'h09);
      prev = pump_clk;
      chk("R9 pump starts low", prev, 0);
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        if (pump_clk != prev) tgl++;
        prev = pump_clk;
      end
      chk($sformatf("R9 toggles div_sel=%0d", d), tgl, 16 >> d);
    end
  endtask

  initial begin
    fork
      begin
        t_reset(); t_layout(); t_excl(); t_arm(); t_margin();
        t_clear_mode(); t_busclk(); t_nosel(); t_pump();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule